// File: doc/BRIEF.md
# Dual-Width Flag ALU

This block is the integer arithmetic and logic stage of a 64-bit datapath. It runs one operation per valid strobe. The operations are add, add with carry-in, subtract, subtract with borrow-in, three bitwise logic operations, and a flag update for a divide. Each operation produces two condition-flag sets at the same time. The narrow set describes the low 32 bits of the result. The wide set describes all 64 bits. Each set has its own carry and its own overflow.

The result and both flag sets are captured on the clock edge where the valid strobe is high. They hold their values until the next strobe. The carry-in for the carry-using operations comes from a separate input, which normally carries the narrow carry flag of the previous operation. For the divide flag update, operand A carries the quotient. A one-bit input says whether the divide overflowed.

Top module: `ccalu_unit`

## Requirements
- R1: A synchronous active-high reset clears the result and both flag sets to zero.
- R2: The result and flags update on the clock edge where `valid_i` is high and are visible from that edge on. While `valid_i` is low they hold their values, whatever the other inputs do.
- R3: Each flag set is packed as bit 3 N, bit 2 Z, bit 1 V, bit 0 C. Narrow Z is set when result bits 31:0 are all zero, and narrow N is result bit 31. Wide Z is set when all 64 result bits are zero, and wide N is result bit 63.
- R4: Opcode 0 (add) gives A+B. In each set, C is 1 when the truncated unsigned sum is below A at that width. V is the sign bit of (~(A^B)) & (A^result) at that width.
- R5: Opcode 1 (add with carry) gives A+B+`carry_i`. When `carry_i` is 1, C is 1 when the truncated sum is at most A at that width. When `carry_i` is 0, the R4 rule applies. V follows the R4 formula.
- R6: Opcode 2 (subtract) gives A-B. In each set, C is 1 when A is unsigned-below B at that width. V is the sign bit of (A^B) & (A^result).
- R7: Opcode 3 (subtract with borrow) gives A-B-`carry_i`. When `carry_i` is 1, C is 1 when A is at most B (unsigned) at that width. When `carry_i` is 0, the R6 rule applies. V follows the R6 formula.
- R8: Opcodes 4, 5 and 6 give A AND B, A OR B and A XOR B. They set only N and Z. V and C are 0 in both sets, whatever the previous flags were.
- R9: Opcode 7 (divide flag update) passes A through as the result and takes N and Z from it. Narrow V equals `div_ovf_i`. Wide V is 0, and C is 0 in both sets.
- R10: `carry_i` has no effect on opcodes 0, 2 and 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Capture strobe for the operation on the inputs |
| op_i | input | 3 | Operation code (R4 to R9) |
| opa_i | input | 64 | Operand A, or the quotient for opcode 7 |
| opb_i | input | 64 | Operand B |
| carry_i | input | 1 | Carry or borrow in for opcodes 1 and 3 |
| div_ovf_i | input | 1 | Divide overflow indication for opcode 7 |
| result_o | output | 64 | Registered result |
| cc_lo_o | output | 4 | Registered 32-bit view flags {N,Z,V,C} |
| cc_hi_o | output | 4 | Registered 64-bit view flags {N,Z,V,C} |

## Verification
The assertions assume that reset is held high from time zero until the first clock edges. They also assume that every input is driven to a known value whenever `valid_i` is high. The opcode-keyed properties assume `op_i` holds a defined 3-bit code on every strobe cycle. The stimulus changes inputs only on falling edges, holds reset for two cycles at the start, and drives every field on each strobe. The idle cycles deliberately change the operands and opcode to exercise the hold property.

// File: rtl/ccalu_pkg.sv
package ccalu_pkg;

    localparam int DATA_W   = 64;
    localparam int NARROW_W = 32;
    localparam int OP_W     = 3;
    localparam int CC_W     = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBC = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_DIVF = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    localparam cc_t CC_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    function automatic logic op_is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBC);
    endfunction

    function automatic logic op_is_add(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC);
    endfunction

    function automatic logic op_takes_carry(alu_op_e op);
        return (op == OP_ADDC) || (op == OP_SUBC);
    endfunction

    function automatic logic op_is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/ccalu_arith.sv
module ccalu_arith
    import ccalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   ext
);
    localparam int EW = W + 1;

    logic [EW-1:0] a_x;
    logic [EW-1:0] b_x;
    logic [EW-1:0] c_x;

    always_comb begin
        a_x = {1'b0, a};
        b_x = {1'b0, b};
        c_x = {{W{1'b0}}, op_takes_carry(op) ? cin : 1'b0};
        unique case (op)
            OP_ADD, OP_ADDC: ext = a_x + b_x + c_x;
            OP_SUB, OP_SUBC: ext = a_x - b_x - c_x;
            OP_AND:          ext = a_x & b_x;
            OP_OR:           ext = a_x | b_x;
            OP_XOR:          ext = a_x ^ b_x;
            default:         ext = a_x;
        endcase
    end
endmodule

// File: rtl/ccalu_flag_gen.sv
module ccalu_flag_gen
    import ccalu_pkg::*;
#(
    parameter int W         = NARROW_W,
    parameter bit HAS_DIV_V = 1'b1
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         carry_out,
    input  logic         div_ovf,
    output cc_t          cc
);
    logic [W-1:0] ovf_add_vec;
    logic [W-1:0] ovf_sub_vec;

    always_comb begin
        ovf_add_vec = ~(a ^ b) & (a ^ r);
        ovf_sub_vec = (a ^ b) & (a ^ r);
        cc   = CC_CLEAR;
        cc.n = r[W-1];
        cc.z = (r == '0);
        if (op_is_add(op)) begin
            cc.c = carry_out;
            cc.v = ovf_add_vec[W-1];
        end else if (op_is_sub(op)) begin
            cc.c = carry_out;
            cc.v = ovf_sub_vec[W-1];
        end else if (op == OP_DIVF) begin
            cc.v = HAS_DIV_V ? div_ovf : 1'b0;
        end
    end
endmodule

// File: rtl/ccalu_unit.sv
module ccalu_unit
    import ccalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              carry_i,
    input  logic              div_ovf_i,
    output logic [DATA_W-1:0] result_o,
    output logic [CC_W-1:0]   cc_lo_o,
    output logic [CC_W-1:0]   cc_hi_o
);
    localparam int NUM_VIEWS = 2;

    alu_op_e           op;
    logic [DATA_W:0]   ext;
    logic [NUM_VIEWS-1:0] view_carry;
    cc_t               view_cc [NUM_VIEWS];

    logic [DATA_W-1:0] result_q;
    cc_t               cc_lo_q;
    cc_t               cc_hi_q;

    assign op = alu_op_e'(op_i);

    ccalu_arith #(.W(DATA_W)) u_arith (
        .op  (op),
        .a   (opa_i),
        .b   (opb_i),
        .cin (carry_i),
        .ext (ext)
    );

    // Carry (or borrow) out of the narrow slice is recovered from the wide
    // sum: the bit-NARROW_W sum equals a ^ b ^ incoming carry for both add
    // and subtract, so the incoming carry is the xor of the three.
    assign view_carry[0] = opa_i[NARROW_W] ^ opb_i[NARROW_W] ^ ext[NARROW_W];
    assign view_carry[1] = ext[DATA_W];

    generate
        for (genvar gi = 0; gi < NUM_VIEWS; gi++) begin : g_view
            localparam int VW = (gi == 0) ? NARROW_W : DATA_W;
            ccalu_flag_gen #(
                .W         (VW),
                .HAS_DIV_V (gi == 0)
            ) u_flags (
                .op        (op),
                .a         (opa_i[VW-1:0]),
                .b         (opb_i[VW-1:0]),
                .r         (ext[VW-1:0]),
                .carry_out (view_carry[gi]),
                .div_ovf   (div_ovf_i),
                .cc        (view_cc[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            cc_lo_q  <= CC_CLEAR;
            cc_hi_q  <= CC_CLEAR;
        end else if (valid_i) begin
            result_q <= ext[DATA_W-1:0];
            cc_lo_q  <= view_cc[0];
            cc_hi_q  <= view_cc[1];
        end
    end

    assign result_o = result_q;
    assign cc_lo_o  = cc_lo_q;
    assign cc_hi_o  = cc_hi_q;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(result_o) && $stable(cc_lo_o) && $stable(cc_hi_o))); // R2

    AST_ZERO_NESTING: assert property (@(posedge clk) disable iff (rst)
        cc_hi_o[2] |-> cc_lo_o[2]); // R3

    AST_ADD_ZERO_B_NO_CV: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd0 && opb_i == '0) |=> (cc_lo_o[1:0] == 2'b00 && cc_hi_o[1:0] == 2'b00)); // R4

    AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == 3'd4 || op_i == 3'd5 || op_i == 3'd6))
            |=> (cc_lo_o[1:0] == 2'b00 && cc_hi_o[1:0] == 2'b00)); // R8

    AST_DIV_WIDE_NO_VC: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd7) |=> (cc_hi_o[1:0] == 2'b00 && cc_lo_o[0] == 1'b0)); // R9

    AST_DIV_PASSES_QUOTIENT: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd7) |=> (result_o == $past(opa_i))); // R9

endmodule

// File: tb/ccalu_unit_test.sv
module ccalu_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic        carry_i = 1'b0;
    logic        div_ovf_i = 1'b0;
    logic [63:0] result_o;
    logic [3:0]  cc_lo_o;
    logic [3:0]  cc_hi_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccalu_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .carry_i(carry_i), .div_ovf_i(div_ovf_i),
        .result_o(result_o), .cc_lo_o(cc_lo_o), .cc_hi_o(cc_hi_o)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirement text (comparison form).
    function automatic logic [71:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                                          logic cin, logic dov);
        logic [63:0] r;
        logic [3:0]  lo, hi;
        logic [63:0] vadd, vsub;
        r = '0; lo = '0; hi = '0;
        case (op)
            3'd0: r = a + b;
            3'd1: r = a + b + {63'd0, cin};
            3'd2: r = a - b;
            3'd3: r = a - b - {63'd0, cin};
            3'd4: r = a & b;
            3'd5: r = a | b;
            3'd6: r = a ^ b;
            default: r = a;
        endcase
        vadd = ~(a ^ b) & (a ^ r);
        vsub = (a ^ b) & (a ^ r);
        lo[3] = r[31];
        lo[2] = (r[31:0] == 32'd0);
        hi[3] = r[63];
        hi[2] = (r == 64'd0);
        case (op)
            3'd0: begin
                lo[0] = r[31:0] < a[31:0];  hi[0] = r < a;
                lo[1] = vadd[31];           hi[1] = vadd[63];
            end
            3'd1: begin
                lo[0] = cin ? (r[31:0] <= a[31:0]) : (r[31:0] < a[31:0]);
                hi[0] = cin ? (r <= a) : (r < a);
                lo[1] = vadd[31];           hi[1] = vadd[63];
            end
            3'd2: begin
                lo[0] = a[31:0] < b[31:0];  hi[0] = a < b;
                lo[1] = vsub[31];           hi[1] = vsub[63];
            end
            3'd3: begin
                lo[0] = cin ? (a[31:0] <= b[31:0]) : (a[31:0] < b[31:0]);
                hi[0] = cin ? (a <= b) : (a < b);
                lo[1] = vsub[31];           hi[1] = vsub[63];
            end
            3'd7: lo[1] = dov;
            default: ;
        endcase
        return {r, lo, hi};
    endfunction

    // Drive one strobe on a falling edge, sample on the following falling edge.
    task automatic run_op(string req, logic [2:0] op, logic [63:0] a, logic [63:0] b,
                          logic cin, logic dov);
        logic [71:0] e;
        e = model(op, a, b, cin, dov);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; carry_i = cin; div_ovf_i = dov; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(req, "result", result_o, e[71:8]);
        check(req, "cc_lo", {60'd0, cc_lo_o}, {60'd0, e[7:4]});
        check(req, "cc_hi", {60'd0, cc_hi_o}, {60'd0, e[3:0]});
    endtask

    task automatic test_reset_state();
        check("R1", "result after reset", result_o, 64'd0);
        check("R1", "cc_lo after reset", {60'd0, cc_lo_o}, 64'd0);
        check("R1", "cc_hi after reset", {60'd0, cc_hi_o}, 64'd0);
    endtask

    task automatic test_add();
        run_op("R4", 3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 1'b0);
        run_op("R4", 3'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, 1'b0);
        run_op("R4", 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0);
        run_op("R4", 3'd0, 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 1'b0, 1'b0);
        run_op("R3", 3'd0, 64'h1234_0000_0000_0000, 64'd0, 1'b0, 1'b0);
        // R10: carry_i must not alter a plain add
        run_op("R10", 3'd0, 64'h0000_0000_FFFF_FFFE, 64'd1, 1'b1, 1'b0);
    endtask

    task automatic test_addc();
        run_op("R5", 3'd1, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        run_op("R5", 3'd1, 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1, 1'b0);
        run_op("R5", 3'd1, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        run_op("R5", 3'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 1'b0);
    endtask

    task automatic test_sub();
        run_op("R6", 3'd2, 64'd3, 64'd5, 1'b0, 1'b0);
        run_op("R6", 3'd2, 64'h8000_0000_0000_0000, 64'd1, 1'b0, 1'b0);
        run_op("R6", 3'd2, 64'h0000_0001_0000_0000, 64'd1, 1'b0, 1'b0);
        run_op("R6", 3'd2, 64'h0000_0000_8000_0000, 64'd1, 1'b0, 1'b0);
        run_op("R10", 3'd2, 64'd9, 64'd9, 1'b1, 1'b0);
    endtask

    task automatic test_subc();
        run_op("R7", 3'd3, 64'd7, 64'd7, 1'b1, 1'b0);
        run_op("R7", 3'd3, 64'd7, 64'd7, 1'b0, 1'b0);
        run_op("R7", 3'd3, 64'h0000_0001_0000_0000, 64'd0, 1'b1, 1'b0);
        run_op("R7", 3'd3, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 1'b0);
    endtask

    task automatic test_logic();
        // leave carry and overflow set first, then show logic clears them
        run_op("R8", 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
        run_op("R8", 3'd4, 64'hF000_0000_8000_0000, 64'hF0F0_0000_8000_0001, 1'b0, 1'b0);
        run_op("R8", 3'd5, 64'h0000_0001_0000_0000, 64'd0, 1'b1, 1'b1);
        run_op("R8", 3'd6, 64'hDEAD_BEEF_DEAD_BEEF, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0, 1'b0);
    endtask

    task automatic test_div();
        run_op("R9", 3'd7, 64'd0, 64'h55, 1'b1, 1'b1);
        run_op("R9", 3'd7, 64'hFFFF_FFFF_8000_0000, 64'd0, 1'b0, 1'b0);
        run_op("R9", 3'd7, 64'h8000_0000_0000_0001, 64'd3, 1'b0, 1'b1);
    endtask

    task automatic test_hold();
        logic [63:0] r0;
        logic [3:0]  l0, h0;
        run_op("R2", 3'd2, 64'd1, 64'd2, 1'b0, 1'b0);
        r0 = result_o; l0 = cc_lo_o; h0 = cc_hi_o;
        @(negedge clk);
        op_i = 3'd6; opa_i = 64'hAAAA; opb_i = 64'h5555; carry_i = 1'b1; div_ovf_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "result held while idle", result_o, r0);
        check("R2", "cc_lo held while idle", {60'd0, cc_lo_o}, {60'd0, l0});
        check("R2", "cc_hi held while idle", {60'd0, cc_hi_o}, {60'd0, h0});
    endtask

    task automatic test_mid_reset();
        run_op("R1", 3'd2, 64'd0, 64'd1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        test_reset_state();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        test_reset_state();
        test_add();
        test_addc();
        test_sub();
        test_subc();
        test_logic();
        test_div();
        test_hold();
        test_mid_reset();
        finish_run();
    end
endmodule